// File: doc/BRIEF.md
# MPU Region Configuration Store

This block holds the region descriptors of a memory protection unit for two privilege banks: a normal bank and a hypervisor bank. Each bank has its own implemented region count, and each region has a base word and a limit word. Software reaches the store through a coprocessor-style access port. Each access carries a valid strobe, a write flag, five encoding fields (`op0`, `op1`, `crn`, `crm`, `op2`) and a 32-bit data word.

A region can be reached in two ways. The indirect path goes through a per-bank selector register and a base window and a limit window. The direct path uses indexed aliases, where the region number is decoded from the encoding fields. Each bank also has a packed enable view: bit n of this view is bit 0 of region n's limit word. Read-only ID registers report the region counts.

Any accepted change to a mapping produces a one-cycle flush pulse, so that downstream lookup caches can discard stale results. The hypervisor region count is limited to 255.

Top module: `mpu_region_store`

## Requirements
- R1: A selector write uses `crn`=6, `crm`=2, `op2`=1, and `op1` bit 1 picks the bank (1 = hypervisor). The selector takes the data only when the data is below that bank's region count; otherwise it keeps its old value. A read of the same encoding returns the selector.
- R2: The window encoding is `crn`=6, `crm`=3, `op2`=0 for base and `op2`=1 for limit, with the bank chosen by `op1` bit 1. Window reads and writes act on the region named by that bank's selector.
- R3: The direct encoding is `crn`=6 with `crm` bit 3 set. The region index is {`op0`[0], `crm`[2:0], `op2`[2]}. `op2` bit 0 chooses limit (1) or base (0), and `op1` bit 1 chooses the hypervisor bank.
- R4: A direct access whose index is at or above the bank's region count changes nothing on a write and returns zero on a read.
- R5: The enable view uses `crn`=6, `crm`=1, `op2`=1, with the bank chosen by `op1` bit 1. On a read, bit n equals bit 0 of region n's limit for n below min(count, 32), and every higher bit reads zero.
- R6: An enable write copies data bit n into bit 0 of region n's limit for n below min(count, 32). It leaves the other limit bits unchanged and drops the data bits at or above the bound.
- R7: The ID encoding is `crn`=0, `crm`=0, `op2`=4. It reads the hypervisor region count when `op1` bit 1 is set, and the normal region count shifted left by 8 otherwise.
- R8: `map_flush` is high for exactly the cycle after an accepted base, limit or enable write. It stays low after reads, after selector writes and after ignored direct writes.
- R9: Read data appears on `rd_data` on the clock edge after the read access and holds until the next read. Writes leave `rd_data` unchanged, and encodings that map to no register read zero.
- R10: Synchronous reset clears all base words, limit words and selectors, and also `rd_data` and `map_flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 (bit 1 = hypervisor bank) |
| acc_crn | input | 4 | Encoding field crn |
| acc_crm | input | 4 | Encoding field crm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wdata | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| map_flush | output | 1 | One-cycle mapping-changed pulse |

## Verification
The hardest situation to reach is the one where the enable view and the region storage disagree in size. This happens when the hypervisor bank has more than 32 regions: regions above 31 can then be reached only through the selector window, never through the enable view or the direct aliases. The bench sizes the hypervisor bank at 40 regions and writes all ones through the enable view. It then moves the selector to region 35 and reads its limit through the window to show that bit 0 is untouched. Random sequences mix selector values on both sides of each bank's count with direct indices on both sides of the smaller count, so that ignored and accepted accesses interleave.

// File: rtl/mpu_store_pkg.sv
package mpu_store_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    K_NONE, K_BASE, K_LIMIT, K_SEL, K_EN, K_ID
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic       hyp;
    logic       direct;
    logic [4:0] idx;
  } acc_dec_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import mpu_store_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output acc_dec_t   dec
);
  always_comb begin
    dec.kind   = K_NONE;
    dec.hyp    = op1[1];
    dec.direct = 1'b0;
    dec.idx    = {op0[0], crm[2:0], op2[2]};
    if (crn == 4'd6) begin
      if (crm[3]) begin
        dec.direct = 1'b1;
        dec.kind   = op2[0] ? K_LIMIT : K_BASE;
      end else if (crm == 4'd3 && op2[2:1] == 2'b00) begin
        dec.kind = op2[0] ? K_LIMIT : K_BASE;
      end else if (crm == 4'd2 && op2 == 3'd1) begin
        dec.kind = K_SEL;
      end else if (crm == 4'd1 && op2 == 3'd1) begin
        dec.kind = K_EN;
      end
    end else if (crn == 4'd0 && crm == 4'd0 && op2 == 3'd4) begin
      dec.kind = K_ID;
    end
  end
endmodule

// File: rtl/region_bank.sv
module region_bank
  import mpu_store_pkg::*;
#(
  parameter int N  = 16,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_sel,
  input  logic             we_base,
  input  logic             we_lim,
  input  logic             we_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] sel_q,
  output logic [DW-1:0]    rd_base,
  output logic [DW-1:0]    rd_lim,
  output logic [31:0]      en_vec,
  output logic             in_rng
);
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int EN_N = (N < 32) ? N : 32;
  localparam logic [IDX_W:0] N_I  = (IDX_W+1)'(N);
  localparam logic [DW-1:0]  N_W  = DW'(N);

  logic [DW-1:0] base_q [N];
  logic [DW-1:0] lim_q  [N];
  logic [IW-1:0] slot;

  assign slot   = idx[IW-1:0];
  assign in_rng = ({1'b0, idx} < N_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      for (int i = 0; i < N; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
    end else begin
      if (we_sel && (wdata < N_W)) sel_q <= wdata[IDX_W-1:0];
      if (we_base && in_rng) base_q[slot] <= wdata;
      if (we_lim && in_rng)  lim_q[slot]  <= wdata;
      if (we_en) begin
        for (int i = 0; i < EN_N; i++) lim_q[i][0] <= wdata[i];
      end
    end
  end

  assign rd_base = in_rng ? base_q[slot] : '0;
  assign rd_lim  = in_rng ? lim_q[slot]  : '0;

  for (genvar g = 0; g < 32; g++) begin : g_en
    if (g < EN_N) begin : g_live
      assign en_vec[g] = lim_q[g][0];
    end else begin : g_zero
      assign en_vec[g] = 1'b0;
    end
  end
endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store
  import mpu_store_pkg::*;
#(
  parameter int NRM_REGIONS = 16,
  parameter int HYP_REGIONS = 40,
  parameter int DW          = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_vld,
  input  logic          acc_wr,
  input  logic [1:0]    acc_op0,
  input  logic [2:0]    acc_op1,
  input  logic [3:0]    acc_crn,
  input  logic [3:0]    acc_crm,
  input  logic [2:0]    acc_op2,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          map_flush
);
  acc_dec_t dec;
  logic [IDX_W-1:0] sel_w  [2];
  logic [IDX_W-1:0] idx_w  [2];
  logic [DW-1:0]    base_w [2];
  logic [DW-1:0]    lim_w  [2];
  logic [31:0]      en_w   [2];
  logic             rng_w  [2];
  logic [DW-1:0]    rnext;
  logic             chg;
  logic             hb;

  acc_decode u_dec (
    .op0(acc_op0), .op1(acc_op1), .crn(acc_crn),
    .crm(acc_crm), .op2(acc_op2), .dec(dec)
  );

  assign hb = dec.hyp;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int NB = (b == 1) ? HYP_REGIONS : NRM_REGIONS;
    logic go;
    assign go       = acc_vld && acc_wr && (dec.hyp == (b == 1));
    assign idx_w[b] = dec.direct ? {3'b000, dec.idx} : sel_w[b];

    region_bank #(.N(NB), .DW(DW)) u_bank (
      .clk(clk), .rst(rst),
      .we_sel (go && dec.kind == K_SEL),
      .we_base(go && dec.kind == K_BASE),
      .we_lim (go && dec.kind == K_LIMIT),
      .we_en  (go && dec.kind == K_EN),
      .idx(idx_w[b]), .wdata(acc_wdata),
      .sel_q(sel_w[b]), .rd_base(base_w[b]), .rd_lim(lim_w[b]),
      .en_vec(en_w[b]), .in_rng(rng_w[b])
    );
  end

  always_comb begin
    case (dec.kind)
      K_BASE:  rnext = base_w[hb];
      K_LIMIT: rnext = lim_w[hb];
      K_SEL:   rnext = DW'(sel_w[hb]);
      K_EN:    rnext = DW'(en_w[hb]);
      K_ID:    rnext = hb ? DW'(HYP_REGIONS) : DW'(NRM_REGIONS << 8);
      default: rnext = '0;
    endcase
  end

  assign chg = acc_vld && acc_wr &&
               ((((dec.kind == K_BASE) || (dec.kind == K_LIMIT)) && rng_w[hb]) ||
                (dec.kind == K_EN));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      map_flush <= 1'b0;
    end else begin
      map_flush <= chg;
      if (acc_vld && !acc_wr) rd_data <= rnext;
    end
  end
endmodule

// File: rtl/mpu_store_chk.sv
module mpu_store_chk #(
  parameter int NRM   = 16,
  parameter int HYP   = 40,
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_vld,
  input logic             acc_wr,
  input logic [2:0]       op1,
  input logic [3:0]       crn,
  input logic [3:0]       crm,
  input logic [2:0]       op2,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rd_data,
  input logic             flush,
  input logic [IDX_W-1:0] sel_n,
  input logic [IDX_W-1:0] sel_h
);
  logic sel_acc, id_acc;
  assign sel_acc = acc_vld && acc_wr && crn == 4'd6 && crm == 4'd2 && op2 == 3'd1;
  assign id_acc  = acc_vld && !acc_wr && crn == 4'd0 && crm == 4'd0 && op2 == 3'd4;

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !flush && sel_n == '0 && sel_h == '0));

  a_r1_sel_bounded: assert property (@(posedge clk) disable iff (rst)
    (32'(sel_n) < 32'(NRM)) && (32'(sel_h) < 32'(HYP)));

  a_r1_sel_ignore_nrm: assert property (@(posedge clk) disable iff (rst)
    (sel_acc && !op1[1] && wdata >= DW'(NRM)) |=> $stable(sel_n));

  a_r1_sel_ignore_hyp: assert property (@(posedge clk) disable iff (rst)
    (sel_acc && op1[1] && wdata >= DW'(HYP)) |=> $stable(sel_h));

  a_r8_flush_cause: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(acc_vld && acc_wr));

  a_r9_write_keeps_rd: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && acc_wr) |=> $stable(rd_data));

  a_r7_id_hyp: assert property (@(posedge clk) disable iff (rst)
    (id_acc && op1[1]) |=> (rd_data == DW'(HYP)));
endmodule

bind mpu_region_store mpu_store_chk #(
  .NRM(NRM_REGIONS), .HYP(HYP_REGIONS), .DW(DW), .IDX_W(mpu_store_pkg::IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr),
  .op1(acc_op1), .crn(acc_crn), .crm(acc_crm), .op2(acc_op2),
  .wdata(acc_wdata), .rd_data(rd_data), .flush(map_flush),
  .sel_n(sel_w[0]), .sel_h(sel_w[1])
);

// File: tb/tb_mpu_region_store.sv
module tb_mpu_region_store;
  localparam int NRM = 16;
  localparam int HYP = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_op0 = '0;
  logic [2:0]  acc_op1 = '0, acc_op2 = '0;
  logic [3:0]  acc_crn = '0, acc_crm = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        map_flush;

  mpu_region_store #(.NRM_REGIONS(NRM), .HYP_REGIONS(HYP), .DW(32)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mb [2][64];
  logic [31:0] ml [2][64];
  int msel [2];
  logic [31:0] last_rd = '0;
  logic [31:0] got_rd;
  logic        got_fl;

  function automatic int cnt(int b); return b ? HYP : NRM; endfunction
  function automatic int ebound(int b); return cnt(b) < 32 ? cnt(b) : 32; endfunction
  function automatic logic [31:0] en_gather(int b);
    logic [31:0] v = '0;
    for (int i = 0; i < ebound(b); i++) v[i] = ml[b][i][0];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(bit wr, logic [1:0] o0, logic [2:0] o1, logic [3:0] n,
                     logic [3:0] m, logic [2:0] o2, logic [31:0] d);
    acc_vld = 1'b1; acc_wr = wr; acc_op0 = o0; acc_op1 = o1;
    acc_crn = n; acc_crm = m; acc_op2 = o2; acc_wdata = d;
    @(negedge clk);
    got_rd = rd_data; got_fl = map_flush;
    acc_vld = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic after_write(string req, bit fl);
    check({req, " flush"}, 32'(got_fl), 32'(fl));
    check("R9 write keeps rd_data", got_rd, last_rd);
  endtask

  task automatic after_read(string req, logic [31:0] exp);
    check(req, got_rd, exp);
    check("R8 no flush on read", 32'(got_fl), 32'd0);
    last_rd = exp;
  endtask

  function automatic logic [2:0] bop1(int b); return b ? 3'b010 : 3'b000; endfunction

  task automatic do_sel(int b, bit wr, logic [31:0] d);
    if (wr) begin
      acc(1, 2'b00, bop1(b), 4'd6, 4'd2, 3'd1, d);
      if (d < 32'(cnt(b))) msel[b] = int'(d);
      after_write("R1 R8", 1'b0);
    end else begin
      acc(0, 2'b00, bop1(b), 4'd6, 4'd2, 3'd1, 32'd0);
      after_read("R1 selector", 32'(msel[b]));
    end
  endtask

  task automatic do_win(int b, bit lim, bit wr, logic [31:0] d);
    int r = msel[b];
    acc(wr, 2'b00, bop1(b), 4'd6, 4'd3, {2'b00, lim}, d);
    if (wr) begin
      if (lim) ml[b][r] = d; else mb[b][r] = d;
      after_write("R2 R8", 1'b1);
    end else begin
      after_read("R2 window", lim ? ml[b][r] : mb[b][r]);
    end
  endtask

  task automatic do_dir(int b, logic [4:0] ix, bit lim, bit wr, logic [31:0] d);
    bit in = int'(ix) < cnt(b);
    acc(wr, {1'b0, ix[4]}, bop1(b), 4'd6, {1'b1, ix[3:1]}, {ix[0], 1'b0, lim}, d);
    if (wr) begin
      if (in) begin
        if (lim) ml[b][ix] = d; else mb[b][ix] = d;
      end
      after_write(in ? "R3 R8" : "R4 R8", in);
    end else begin
      after_read(in ? "R3 direct" : "R4 direct out of range",
                 in ? (lim ? ml[b][ix] : mb[b][ix]) : 32'd0);
    end
  endtask

  task automatic do_en(int b, bit wr, logic [31:0] d);
    acc(wr, 2'b00, bop1(b), 4'd6, 4'd1, 3'd1, d);
    if (wr) begin
      for (int i = 0; i < ebound(b); i++) ml[b][i][0] = d[i];
      after_write("R6 R8", 1'b1);
    end else begin
      after_read("R5 enable view", en_gather(b));
    end
  endtask

  task automatic do_id(int b);
    acc(0, 2'b00, bop1(b), 4'd0, 4'd0, 3'd4, 32'd0);
    after_read("R7 id", b ? 32'(HYP) : 32'(NRM << 8));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int b = 0; b < 2; b++) begin
      msel[b] = 0;
      for (int i = 0; i < 64; i++) begin mb[b][i] = '0; ml[b][i] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rd_data after reset", rd_data, 32'd0);
    check("R10 flush after reset", 32'(map_flush), 32'd0);
    do_sel(0, 0, 0); do_sel(1, 0, 0);
    do_win(0, 0, 0, 0); do_win(1, 1, 0, 0); do_en(1, 0, 0);

    // R1 boundaries
    do_sel(0, 1, 32'd16); do_sel(0, 0, 0);
    do_sel(0, 1, 32'd15); do_sel(0, 0, 0);
    do_sel(1, 1, 32'd39); do_sel(1, 0, 0);
    do_sel(1, 1, 32'd40); do_sel(1, 0, 0);
    // R2 window on top hyp region
    do_win(1, 0, 1, 32'hCAFE_0039); do_win(1, 0, 0, 0);
    // R4 normal direct beyond count
    do_dir(0, 5'd20, 1, 1, 32'h1234_5678); do_dir(0, 5'd20, 1, 0, 0);
    // R3 hyp direct index 31 uses op0[0]
    do_dir(1, 5'd31, 1, 1, 32'hA5A5_0002); do_dir(1, 5'd31, 1, 0, 0);
    // R6 enable bound: region 35 untouched
    do_sel(1, 1, 32'd35); do_win(1, 1, 1, 32'h0000_1000);
    do_en(1, 1, 32'hFFFF_FFFF); do_en(1, 0, 0);
    do_win(1, 1, 0, 0);
    check("R6 region 35 limit bit0 kept", ml[1][35], 32'h0000_1000);
    // R5 normal enable bound
    do_en(0, 1, 32'hFFFF_FFFF); do_en(0, 0, 0);
    check("R5 upper bits zero", last_rd, 32'h0000_FFFF);
    // R9 unmapped encoding
    acc(0, 2'b00, 3'b000, 4'd5, 4'd0, 3'd0, 32'd0);
    after_read("R9 unmapped reads zero", 32'd0);
    do_id(0); do_id(1);

    for (int k = 0; k < 400; k++) begin
      int b = int'($urandom_range(0, 1));
      bit wr = 1'($urandom_range(0, 1));
      logic [31:0] d = $urandom;
      case ($urandom_range(0, 4))
        0: do_sel(b, wr, 32'($urandom_range(0, 50)));
        1: do_win(b, 1'($urandom_range(0, 1)), wr, d);
        2: do_dir(b, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), wr, d);
        3: do_en(b, wr, d);
        default: do_id(b);
      endcase
    end
    summary();
  end
endmodule